// File: doc/BRIEF.md
# Frame-Based PWM Noise-Shaping DAC Modulator

This block turns a stream of signed, oversampled audio samples into a one-bit pulse-width stream. That stream drives a short line of equal-weight delay taps, which is the digital half of a moving-average FIR DAC. A second-order error-feedback noise shaper, built from shifts and adds only, reduces each sample to an integer duty between 0 and 14 clocks. A frame generator then plays that duty as one pulse per 14-clock frame, with the pulse starting on the frame's first clock. The output can switch at most once upward per frame, so the switching rate is the master clock divided by 14. The master clock is 512 times the base audio rate, and the logic is the same for either audio clock family.

The tap line is a 14-stage shift register fed by the pulse stream. Each stage is brought out twice: once true and once inverted, both from their own registers, so that an external differential resistor network can sum them. Summing the taps with equal weight averages out the frame-rate spurs. The block accepts at most one input sample per frame through a ready/valid handshake. When no sample is offered, the last accepted sample stays in use.

Top module: `pwm_ns_dac`

## Requirements
- R1: `frame_strb` pulses for one clock at the start of every frame, and consecutive pulses are exactly 14 clocks apart. In the cycle of the pulse, `tap_p[0]` shows the frame's first pulse bit.
- R2: Within each frame the bits on `tap_p[0]` are a run of ones starting at the frame's first bit, followed only by zeros. The duty (the count of ones) lies in 0..14, so `tap_p[0]` rises at most once per frame and only on the first bit.
- R3: For a constant input sample s (16-bit two's complement), the mean duty over 64 frames stays within 1 of 7 + 7*s/32768.
- R4: A zero input gives a duty of exactly 7 in every frame.
- R5: The most negative input (-32768) gives a duty of exactly 0 in every frame once settled. The most positive input keeps every duty within 0..14 and the mean within 1 of the R3 target.
- R6: After one sample is accepted, later changes to `in_data` while `in_valid` is low have no effect: the mean duty keeps tracking the accepted sample.
- R7: `in_ready` is high for exactly one clock per frame, and `frame_strb` follows it two clocks later. A sample is taken when `in_valid` and `in_ready` are both high at a rising clock edge.
- R8: On every clock, `tap_p[i]` equals the value `tap_p[i-1]` held one clock earlier, for i = 1..13, and `tap_n` is the bitwise inverse of `tap_p`.
- R9: While `rst` is high, `tap_p` holds the alternating pattern with bit 0 set (14'h1555, seven ones), `tap_n` holds its inverse, and `in_ready` and `frame_strb` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock, 512 times the base audio rate |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 16 | Signed input sample, two's complement |
| in_valid | input | 1 | A sample is offered on in_data |
| in_ready | output | 1 | The block takes a sample at this clock edge |
| tap_p | output | 14 | True outputs of the tap shift register; bit 0 is the newest |
| tap_n | output | 14 | Inverted outputs of the tap shift register |
| frame_strb | output | 1 | First bit of a frame is on tap_p[0] |

## Verification
Two situations are hard to reach from the ports. The first is driving the shaper into clamping at the most negative input. The second is letting its error registers creep at the most positive input, where the quantizer sits one part in 256 below its top level. Both are reached by holding these extreme samples for many frames and measuring each frame's pulse shape on `tap_p[0]`. The hold behaviour is reached by completing exactly one handshake, then dropping valid and driving an unrelated value on the data bus while the duty average is measured.

// File: rtl/pwm_ns_pkg.sv
package pwm_ns_pkg;
  // Reset value of tap stage i: alternating ones and zeros, bit 0 set.
  function automatic logic alt_bit(input int i);
    return (i % 2) == 0;
  endfunction
endpackage

// File: rtl/pwm_ns_shaper.sv
// Second-order error-feedback shaper with a saturating duty quantizer.
// Updated once per frame; no multipliers (x7 = x8 - x1, x2 = shift).
module pwm_ns_shaper #(
  parameter int DATA_W    = 16,
  parameter int FRAME_LEN = 14,
  parameter int FRAC_W    = 8,
  parameter int DUTY_W    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic [DATA_W-1:0] samp,
  output logic [DUTY_W-1:0] duty
);
  localparam int VW    = FRAC_W + 6;
  localparam int SHIFT = DATA_W - 1 - FRAC_W;
  localparam int MID   = FRAME_LEN / 2;
  localparam logic signed [VW-1:0] HALF_V = VW'(2 ** (FRAC_W - 1));
  localparam logic signed [VW-1:0] ONE_V  = VW'(2 ** FRAC_W);
  localparam logic signed [VW-1:0] QMAX   = VW'(MID);
  localparam logic signed [VW-1:0] QMIN   = -QMAX;

  logic signed [DATA_W+2:0] s_ext, s7, s7_sh;
  logic signed [VW-1:0] xv, yv, yr, qi, qc, qv, er, ec, dsum;
  logic signed [VW-1:0] e1_q, e2_q;
  logic [DUTY_W-1:0]    duty_q;

  always_comb begin
    s_ext = {{3{samp[DATA_W-1]}}, samp};
    s7    = (s_ext <<< 3) - s_ext;
    s7_sh = s7 >>> SHIFT;
    xv    = s7_sh[VW-1:0];
    yv    = xv - (e1_q <<< 1) + e2_q;
    yr    = yv + HALF_V;
    qi    = yr >>> FRAC_W;
    if (qi > QMAX)      qc = QMAX;
    else if (qi < QMIN) qc = QMIN;
    else                qc = qi;
    qv    = qc <<< FRAC_W;
    er    = qv - yv;
    if (er > ONE_V)       ec = ONE_V;
    else if (er < -ONE_V) ec = -ONE_V;
    else                  ec = er;
    dsum  = qc + QMAX;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      e1_q   <= '0;
      e2_q   <= '0;
      duty_q <= DUTY_W'(MID);
    end else if (adv) begin
      e2_q   <= e1_q;
      e1_q   <= ec;
      duty_q <= dsum[DUTY_W-1:0];
    end
  end

  assign duty = duty_q;
endmodule

// File: rtl/pwm_ns_framer.sv
// Frame counter, sample capture handshake and high-first pulse bit.
module pwm_ns_framer #(
  parameter int DATA_W    = 16,
  parameter int FRAME_LEN = 14,
  parameter int DUTY_W    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  input  logic [DUTY_W-1:0] duty,
  output logic              in_ready,
  output logic              frame_strb,
  output logic [DATA_W-1:0] samp,
  output logic              adv,
  output logic              pwm_bit
);
  localparam int CW   = $clog2(FRAME_LEN);
  localparam int LAST = FRAME_LEN - 1;

  logic [CW-1:0]     cnt_q;
  logic              ready_q, strb_q;
  logic [DATA_W-1:0] samp_q;
  logic [DUTY_W-1:0] cnt_ext;

  assign adv     = (cnt_q == CW'(LAST));
  assign cnt_ext = DUTY_W'(cnt_q);
  assign pwm_bit = (cnt_ext < duty);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      ready_q <= 1'b0;
      strb_q  <= 1'b0;
      samp_q  <= '0;
    end else begin
      cnt_q   <= adv ? '0 : cnt_q + 1'b1;
      ready_q <= (cnt_q == CW'(LAST - 1));
      strb_q  <= (cnt_q == '0);
      if (ready_q && in_valid) samp_q <= in_data;
    end
  end

  assign in_ready   = ready_q;
  assign frame_strb = strb_q;
  assign samp       = samp_q;
endmodule

// File: rtl/pwm_ns_tapline.sv
// Equal-weight FIR DAC tap line with separately registered complements.
module pwm_ns_tapline #(
  parameter int TAPS = 14
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            din,
  output logic [TAPS-1:0] tap_p,
  output logic [TAPS-1:0] tap_n
);
  logic [TAPS-1:0] p_q, n_q, nxt;

  for (genvar i = 0; i < TAPS; i++) begin : g_stage
    localparam logic RV = pwm_ns_pkg::alt_bit(i);
    if (i == 0) begin : g_head
      assign nxt[i] = din;
    end else begin : g_body
      assign nxt[i] = p_q[i-1];
    end
    always_ff @(posedge clk) begin
      if (rst) begin
        p_q[i] <= RV;
        n_q[i] <= ~RV;
      end else begin
        p_q[i] <= nxt[i];
        n_q[i] <= ~nxt[i];
      end
    end
  end

  assign tap_p = p_q;
  assign tap_n = n_q;
endmodule

// File: rtl/pwm_ns_dac.sv
module pwm_ns_dac #(
  parameter int DATA_W    = 16,
  parameter int FRAME_LEN = 14,
  parameter int TAPS      = 14,
  parameter int FRAC_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic [TAPS-1:0]   tap_p,
  output logic [TAPS-1:0]   tap_n,
  output logic              frame_strb
);
  localparam int DUTY_W = $clog2(FRAME_LEN + 1);

  logic [DATA_W-1:0] samp;
  logic [DUTY_W-1:0] duty;
  logic              adv, pwm_bit;

  pwm_ns_framer #(.DATA_W(DATA_W), .FRAME_LEN(FRAME_LEN), .DUTY_W(DUTY_W)) framer_i (
    .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid), .duty(duty),
    .in_ready(in_ready), .frame_strb(frame_strb), .samp(samp), .adv(adv),
    .pwm_bit(pwm_bit)
  );

  pwm_ns_shaper #(.DATA_W(DATA_W), .FRAME_LEN(FRAME_LEN), .FRAC_W(FRAC_W),
                  .DUTY_W(DUTY_W)) shaper_i (
    .clk(clk), .rst(rst), .adv(adv), .samp(samp), .duty(duty)
  );

  pwm_ns_tapline #(.TAPS(TAPS)) taps_i (
    .clk(clk), .rst(rst), .din(pwm_bit), .tap_p(tap_p), .tap_n(tap_n)
  );
endmodule

// File: rtl/pwm_ns_dac_chk.sv
module pwm_ns_dac_chk #(
  parameter int FRAME_LEN = 14,
  parameter int TAPS      = 14
) (
  input logic            clk,
  input logic            rst,
  input logic            in_ready,
  input logic            frame_strb,
  input logic [TAPS-1:0] tap_p,
  input logic [TAPS-1:0] tap_n
);
  localparam int GW = $clog2(FRAME_LEN + 1) + 1;
  logic [GW-1:0] gap_q;
  logic          seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (frame_strb) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else if (gap_q != '1) begin
      gap_q  <= gap_q + 1'b1;
    end
  end

  // R1: strobes exactly FRAME_LEN clocks apart
  a_r1_strobe_period: assert property (@(posedge clk) disable iff (rst)
    (frame_strb && seen_q) |-> (gap_q == GW'(FRAME_LEN - 1)));
  a_r1_no_missing_strobe: assert property (@(posedge clk) disable iff (rst)
    seen_q |-> (gap_q < GW'(FRAME_LEN)));
  // R2: the pulse bit only rises on a frame's first bit
  a_r2_rise_at_start: assert property (@(posedge clk) disable iff (rst)
    $rose(tap_p[0]) |-> frame_strb);
  // R7: ready precedes the strobe by two clocks
  a_r7_ready_leads_strobe: assert property (@(posedge clk) disable iff (rst)
    in_ready |=> ##1 frame_strb);
  // R8: tap line shifts by one stage per clock
  a_r8_tap_shift: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (tap_p[TAPS-1:1] == $past(tap_p[TAPS-2:0])));
  // R8: complement outputs
  a_r8_complement: assert property (@(posedge clk) disable iff (rst)
    tap_n == ~tap_p);
endmodule

bind pwm_ns_dac pwm_ns_dac_chk #(.FRAME_LEN(FRAME_LEN), .TAPS(TAPS)) chk_i (
  .clk(clk), .rst(rst), .in_ready(in_ready), .frame_strb(frame_strb),
  .tap_p(tap_p), .tap_n(tap_n)
);

// File: tb/pwm_ns_dac_tb_top.sv
`timescale 1ns/1ps
module pwm_ns_dac_tb_top;
  localparam int NT = 14;
  logic clk = 1'b0, rst = 1'b1;
  logic [15:0] in_data = '0;
  logic in_valid = 1'b0;
  logic in_ready, frame_strb;
  logic [NT-1:0] tap_p, tap_n;
  int n_chk = 0, n_fail = 0;
  int r8_err = 0;
  logic [NT-1:0] prev_p;
  bit prev_ok = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pwm_ns_dac dut_i (.clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .tap_p(tap_p), .tap_n(tap_n), .frame_strb(frame_strb));

  // R8 monitor: shift and complement on every clock after reset
  always @(negedge clk) begin
    if (rst) prev_ok = 0;
    else begin
      if (prev_ok && tap_p[NT-1:1] != prev_p[NT-2:0]) r8_err++;
      if (tap_n != ~tap_p) r8_err++;
      prev_p  = tap_p;
      prev_ok = 1;
    end
  end

  task automatic check(input bit ok, input string req, input real act, input real exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0.4f expected %0.4f", req, act, exp);
    end
  endtask

  // Measure nfr frames on tap_p[0]; shape_err counts R1/R2 violations
  task automatic measure(input int nfr, output real mean, output int dmin,
                         output int dmax, output int shape_err);
    int sum = 0;
    shape_err = 0; dmin = 99; dmax = -1;
    do @(negedge clk); while (!frame_strb);
    for (int f = 0; f < nfr; f++) begin
      int ones = 0;
      bit low_seen = 0;
      for (int k = 0; k < NT; k++) begin
        if ((k == 0) != frame_strb) shape_err++;
        if (tap_p[0] && low_seen) shape_err++;
        if (!tap_p[0]) low_seen = 1;
        ones += int'(tap_p[0]);
        @(negedge clk);
      end
      sum += ones;
      if (ones < dmin) dmin = ones;
      if (ones > dmax) dmax = ones;
    end
    mean = real'(sum) / nfr;
  endtask

  task automatic apply(input int s);
    in_data  = 16'(s);
    in_valid = 1'b1;
    repeat (6 * NT) @(negedge clk);
  endtask

  function automatic real target(input int s);
    return 7.0 + 7.0 * real'(s) / 32768.0;
  endfunction

  task automatic t_reset;
    @(negedge clk);
    check(tap_p == 14'h1555, "R9 tap_p reset", real'(tap_p), real'(14'h1555));
    check(tap_n == ~14'h1555, "R9 tap_n reset", real'(tap_n), real'(~14'h1555 & 14'h3fff));
    check(!frame_strb && !in_ready, "R9 strobe/ready low", real'(frame_strb | in_ready), 0.0);
  endtask

  task automatic t_zero;
    real m; int lo, hi, se;
    apply(0);
    measure(32, m, lo, hi, se);
    check(lo == 7 && hi == 7, "R4 duty 7 every frame (min)", real'(lo), 7.0);
    check(se == 0, "R1/R2 frame shape zero input", real'(se), 0.0);
  endtask

  task automatic t_dc(input int s);
    real m; int lo, hi, se;
    apply(s);
    measure(64, m, lo, hi, se);
    check((m - target(s)) <= 1.0 && (target(s) - m) <= 1.0, "R3 mean duty", m, target(s));
    check(se == 0 && lo >= 0 && hi <= 14, "R2 high-first shape", real'(se), 0.0);
  endtask

  task automatic t_full;
    real m; int lo, hi, se;
    apply(-32768);
    measure(32, m, lo, hi, se);
    check(hi == 0, "R5 negative full scale duty 0", real'(hi), 0.0);
    apply(32767);
    measure(64, m, lo, hi, se);
    check(hi <= 14 && lo >= 0 && se == 0, "R5 positive full scale range", real'(hi), 14.0);
    check((target(32767) - m) <= 1.0 && (m - target(32767)) <= 1.0, "R5 positive mean",
          m, target(32767));
  endtask

  task automatic t_hold;
    real m; int lo, hi, se;
    in_data = 16'(-16384); in_valid = 1'b1;
    do @(negedge clk); while (!in_ready);
    @(negedge clk);
    in_valid = 1'b0; in_data = 16'(20000);
    repeat (6 * NT) @(negedge clk);
    measure(64, m, lo, hi, se);
    check((m - target(-16384)) <= 1.0 && (target(-16384) - m) <= 1.0,
          "R6 held sample unaffected by in_data", m, target(-16384));
  endtask

  task automatic t_ready;
    int nr = 0, gap = -1;
    do @(negedge clk); while (!frame_strb);
    for (int k = 0; k < 2 * NT; k++) begin
      if (in_ready) begin nr++; gap = 0; end
      else if (gap >= 0) gap++;
      if (frame_strb && k > 0) check(gap == 2, "R7 strobe two clocks after ready",
                                     real'(gap), 2.0);
      @(negedge clk);
    end
    check(nr == 2, "R7 one ready per frame", real'(nr), 2.0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    t_reset();
    @(negedge clk) rst = 1'b0;
    t_zero();
    t_dc(16384);
    t_dc(-12000);
    t_dc(3000);
    t_full();
    t_hold();
    t_ready();
    check(r8_err == 0, "R8 tap shift and complement", real'(r8_err), 0.0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule